// File: doc/BRIEF.md
# Output DMA Address Offset Sequencer

This block sits beside the output FIFO of a pixel decoder. For every 32-bit word that the DMA engine pops from that FIFO, it supplies a signed word offset. The DMA engine adds that offset to its running destination address. The target framebuffer holds a strip of pixels as two 8-row tiles placed side by side. Rows 0 to 7 land at multiples of the row stride. Rows 8 to 15 are pulled back by seven strides, so they reuse the vertical positions of the first tile while the DMA engine's own linear advance shifts them to the right.

The sequencer holds two counters. A word counter counts the words left in the current row. A 4-bit row counter moves forward each time a row's worth of words has been read. A read only counts when the strobe comes while the FIFO is not empty. Any other cycle reports a zero offset and leaves both counters alone. A synchronous reload input, or the synchronous reset, starts a new strip.

Top module: `dma_ofs_seq`

## Requirements
- R1: On an accepted read (`rd_stb`=1 and `fifo_empty`=0) with row counter value r in 0..7, `ofs_valid` is 1 in the same cycle and `ofs` equals (r mod 8) × `stride`.
- R2: On an accepted read with r in 8..15, `ofs` equals (r mod 8) × `stride` − 7 × `stride`, given as an OFF_W-bit two's-complement value with OFF_W = STRIDE_W + 4. Row 8 therefore gives −7 × `stride` and row 15 gives 0.
- R3: Each row lasts exactly `stride` accepted reads. When a row begins, the word counter takes the `stride` value present at that clock edge. A `stride` of 0 behaves as 1.
- R4: After the last word of a row, the row counter advances by one, wrapping from 15 back to 0.
- R5: In a cycle with no strobe, or with a strobe while `fifo_empty`=1, `ofs_valid` is 0, `ofs` is 0, and neither counter changes.
- R6: `reload`=1 sets the row counter to 0 and the word counter to `stride` at the next edge. This takes priority over a read in the same cycle. That read still reports the offset of the current row.
- R7: While `rst_n` is low (sampled synchronously), the block behaves as under R6. After release, `ofs_valid` is 0 and the first accepted read reports offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reload | input | 1 | Synchronous strip restart |
| stride | input | STRIDE_W | Row stride in 32-bit words |
| rd_stb | input | 1 | DMA read strobe |
| fifo_empty | input | 1 | Output FIFO has no word |
| ofs_valid | output | 1 | Offset belongs to an accepted read |
| ofs | output | STRIDE_W+4 | Signed word offset for this read |

## Verification
The checker tests these rules on every cycle: the idle and empty-FIFO cycles report zero and leave both counters unchanged, the word counter steps down by one, the row advances by one at a row end, reload returns the row to zero, and the sign of the offset matches the half of the strip the row belongs to. The exact offset values, the number of reads per row, the wrap from row 15 to row 0, a stride change between rows, and the stride-zero case are only shown by the bench's scenarios. In those scenarios an independent model predicts every cycle's offset.

// File: rtl/dma_ofs_pkg.sv
package dma_ofs_pkg;
  localparam int ROW_W      = 4;   // strip height 16 rows, two 8-row tiles
  localparam int TILE_ROWS  = 8;
  localparam int FOLD_MULT  = TILE_ROWS - 1;
  typedef logic [ROW_W-1:0] row_t;
endpackage

// File: rtl/dma_ofs_wordcnt.sv
module dma_ofs_wordcnt #(
  parameter int STRIDE_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reload,
  input  logic [STRIDE_W-1:0] stride,
  input  logic                rd_fire,
  output logic                row_end,
  output logic [STRIDE_W-1:0] cnt_q
);
  logic last_word;

  // a count of one (or zero when stride is zero) marks the final word
  assign last_word = (cnt_q <= STRIDE_W'(1));
  assign row_end   = rd_fire && last_word;

  always_ff @(posedge clk) begin
    if (!rst_n || reload) begin
      cnt_q <= stride;
    end else if (rd_fire) begin
      cnt_q <= last_word ? stride : cnt_q - STRIDE_W'(1);
    end
  end
endmodule

// File: rtl/dma_ofs_rowcnt.sv
module dma_ofs_rowcnt
  import dma_ofs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic reload,
  input  logic row_end,
  output row_t row_q
);
  always_ff @(posedge clk) begin
    if (!rst_n || reload) begin
      row_q <= '0;
    end else if (row_end) begin
      row_q <= row_q + row_t'(1);  // natural wrap 15 -> 0
    end
  end
endmodule

// File: rtl/dma_ofs_calc.sv
module dma_ofs_calc
  import dma_ofs_pkg::*;
#(
  parameter int STRIDE_W = 10,
  localparam int OFF_W   = STRIDE_W + ROW_W
) (
  input  row_t                    row,
  input  logic [STRIDE_W-1:0]     stride,
  input  logic                    rd_fire,
  output logic signed [OFF_W-1:0] ofs
);
  // row position inside a tile times the stride
  function automatic logic [OFF_W-1:0] tile_pos(input row_t r, input logic [STRIDE_W-1:0] s);
    return OFF_W'(r[ROW_W-2:0]) * OFF_W'(s);
  endfunction

  // pull-back applied to the second tile
  function automatic logic [OFF_W-1:0] fold_back(input row_t r, input logic [STRIDE_W-1:0] s);
    return r[ROW_W-1] ? OFF_W'(FOLD_MULT) * OFF_W'(s) : '0;
  endfunction

  logic [OFF_W-1:0] raw;
  assign raw = tile_pos(row, stride) - fold_back(row, stride);
  assign ofs = rd_fire ? $signed(raw) : '0;
endmodule

// File: rtl/dma_ofs_seq.sv
module dma_ofs_seq
  import dma_ofs_pkg::*;
#(
  parameter int STRIDE_W = 10,
  localparam int OFF_W   = STRIDE_W + ROW_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reload,
  input  logic [STRIDE_W-1:0]     stride,
  input  logic                    rd_stb,
  input  logic                    fifo_empty,
  output logic                    ofs_valid,
  output logic signed [OFF_W-1:0] ofs
);
  logic                rd_fire;
  logic                row_end;
  logic [STRIDE_W-1:0] word_cnt;
  row_t                row_q;

  assign rd_fire   = rd_stb && !fifo_empty;
  assign ofs_valid = rd_fire;

  dma_ofs_wordcnt #(.STRIDE_W(STRIDE_W)) u_wordcnt (
    .clk(clk), .rst_n(rst_n), .reload(reload), .stride(stride),
    .rd_fire(rd_fire), .row_end(row_end), .cnt_q(word_cnt)
  );

  dma_ofs_rowcnt u_rowcnt (
    .clk(clk), .rst_n(rst_n), .reload(reload), .row_end(row_end), .row_q(row_q)
  );

  dma_ofs_calc #(.STRIDE_W(STRIDE_W)) u_calc (
    .row(row_q), .stride(stride), .rd_fire(rd_fire), .ofs(ofs)
  );
endmodule

// File: rtl/dma_ofs_seq_chk.sv
module dma_ofs_seq_chk
  import dma_ofs_pkg::*;
#(
  parameter int STRIDE_W = 10,
  localparam int OFF_W   = STRIDE_W + ROW_W
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    reload,
  input logic                    rd_fire,
  input logic                    row_end,
  input logic [STRIDE_W-1:0]     word_cnt,
  input row_t                    row_q,
  input logic                    ofs_valid,
  input logic signed [OFF_W-1:0] ofs
);
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !ofs_valid |-> ofs == '0);  // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_fire && !reload) |=> ($stable(row_q) && $stable(word_cnt)));  // R5
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !row_end && !reload) |=> word_cnt == $past(word_cnt) - STRIDE_W'(1));  // R3
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (row_end && !reload) |=> row_q == $past(row_q) + row_t'(1));  // R4
  AST_RELOAD_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> row_q == '0);  // R6
  AST_LOW_TILE_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs_valid && !row_q[ROW_W-1]) |-> ofs >= 0);  // R1
  AST_HIGH_TILE_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs_valid && row_q[ROW_W-1]) |-> ofs <= 0);  // R2
endmodule

bind dma_ofs_seq dma_ofs_seq_chk #(.STRIDE_W(STRIDE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reload(reload), .rd_fire(rd_fire),
  .row_end(row_end), .word_cnt(word_cnt), .row_q(row_q),
  .ofs_valid(ofs_valid), .ofs(ofs)
);

// File: tb/dma_ofs_seq_test.sv
module dma_ofs_seq_test;
  localparam int SW = 10;
  localparam int OW = SW + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reload = 1'b0;
  logic [SW-1:0] stride = SW'(3);
  logic rd_stb = 1'b0;
  logic fifo_empty = 1'b1;
  logic ofs_valid;
  logic signed [OW-1:0] ofs;

  int errors = 0;
  int checks = 0;

  typedef struct {
    bit    vld;
    int    off;
    string req;
  } exp_t;
  exp_t sbq[$];

  int m_row;
  int m_cnt;

  always #10 clk = ~clk;  // 50 MHz

  dma_ofs_seq #(.STRIDE_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .reload(reload), .stride(stride),
    .rd_stb(rd_stb), .fifo_empty(fifo_empty), .ofs_valid(ofs_valid), .ofs(ofs)
  );

  function automatic int model_off(int r, int s);
    int lo = r % 8;
    return (r >= 8) ? (lo - 7) * s : lo * s;
  endfunction

  task automatic check(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // driver: one item per cycle
  task automatic step(bit stb, bit emp, bit rel, int s, string req);
    exp_t e;
    int se;
    @(posedge clk);
    #2;
    rd_stb = stb; fifo_empty = emp; reload = rel; stride = SW'(s);
    se = (s == 0) ? 1 : s;
    e.vld = stb && !emp;
    e.off = e.vld ? model_off(m_row, s) : 0;
    e.req = req;
    sbq.push_back(e);
    if (rel) begin
      m_row = 0; m_cnt = s;
    end else if (e.vld) begin
      if (m_cnt <= 1) begin m_cnt = s; m_row = (m_row + 1) % 16; end
      else m_cnt--;
    end
    if (se == 0) m_cnt = 0;
  endtask

  // monitor: compare away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        check({e.req, " valid"}, int'(ofs_valid), int'(e.vld));
        check({e.req, " ofs"}, int'(ofs), e.off);
      end
    end
  end

  task automatic reads(int n, int s, string req);
    for (int i = 0; i < n; i++) step(1, 0, 0, s, req);
  endtask

  initial begin
    #100000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_row = 0; m_cnt = 3;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check("R7 reset valid", int'(ofs_valid), 0);
    check("R7 reset ofs", int'(ofs), 0);

    // full strip with stride 3, wrapping past row 15
    reads(3 * 16 + 5, 3, "R1/R2/R3/R4 stride3");

    // idle and empty-FIFO strobes interleaved
    for (int i = 0; i < 20; i++) begin
      step(i % 3 == 1, i % 3 == 2, 0, 3, "R5 gaps");
      step(1, 1, 0, 3, "R5 empty");
      step(0, 0, 0, 3, "R5 idle");
    end

    // reload mid-strip, with a read in the same cycle
    step(1, 0, 1, 5, "R6 reload+read");
    reads(5 * 10, 5, "R6 after reload");

    // large stride reaching the second tile
    step(0, 0, 1, 1023, "R6 reload");
    reads(1023 * 9 + 2, 1023, "R2 max stride");

    // stride zero acts as one
    step(0, 0, 1, 0, "R6 reload");
    reads(20, 0, "R3 stride0");

    // stride change between rows
    step(0, 0, 1, 2, "R6 reload");
    reads(4, 2, "R3 stride2");
    reads(12, 4, "R3 stride4");

    // synchronous reset mid-run
    @(posedge clk); #2 rst_n = 1'b0; rd_stb = 1'b0; stride = SW'(6);
    @(posedge clk); #2 rst_n = 1'b1;
    m_row = 0; m_cnt = 6;
    reads(20, 6, "R7 after reset");
    step(0, 0, 0, 6, "R5 idle");

    repeat (3) @(posedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule